// File: doc/BRIEF.md
# Fixed-point YUV to RGBA pixel converter

This block turns luma and chroma samples into packed 8-bit RGBA pixels using integer arithmetic only. Each cycle it takes `LANES` luma samples (two by default) that share one chroma pair (U, V), and three cycles later it presents one 32-bit RGBA word per luma sample. The equations have been rearranged so that every intermediate value fits in 16 unsigned bits. Halving adds keep the large chroma products in range, and saturating operations clamp the results at zero and at the 16-bit ceiling.

The common luma term is 149·Y. Red and blue each build a sum that is halved once, then take away a fixed offset, and are narrowed with a rounding shift of 6. Green adds a fixed offset to the luma term, takes away a combined chroma term, and is narrowed with a rounding shift of 7. Alpha is always opaque. The block suits a streaming video pipeline in which chroma upsampling, memory access and line control all happen upstream. The datapath advances every cycle, and a valid strobe travels alongside the data.

Top module: `yuv_rgba_conv`

## Requirements
- R1: `out_valid` equals `in_valid` delayed by exactly 3 clock cycles. The pixels on `out_rgba` in that cycle belong to the inputs sampled 3 cycles earlier.
- R2: Red is computed as follows. Let T = (149·Y + (V>>1) + 204·V) >> 1, truncated. Then R = max(T − 14280, 0) before narrowing.
- R3: Green is computed as follows. Let S = min(149·Y + 17328, 65535). Then G = max(S − (50·U + 104·V), 0) before narrowing.
- R4: Blue is computed as follows. Let T = (149·Y + 4·U + 254·U) >> 1, truncated. Then B = max(T − 17704, 0) before narrowing.
- R5: Red and blue narrow to 8 bits as min((x + 32) >> 6, 255). Green narrows as min((x + 64) >> 7, 255). For example, Y=255, U=V=255 gives red and blue of 255.
- R6: Each 32-bit pixel holds red in bits 7:0, green in bits 15:8, blue in bits 23:16 and alpha in bits 31:24, so the byte order in memory is R, G, B, A. Alpha is always 0xFF on a valid output.
- R7: Lane i takes its luma from `in_y[8i+7:8i]` and delivers its pixel on `out_rgba[32i+31:32i]`. All lanes use the same U and V.
- R8: Holding `rst_n` low at a clock edge clears `out_valid` and `out_rgba` to 0, whatever the inputs are.
- R9: An intermediate that would go below zero clamps to 0 and gives an 8-bit channel of 0. For example, Y=0, U=V=128 gives red 0 and blue 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input samples are valid |
| in_y | input | LANES*8 | Luma samples, lane 0 in the low byte |
| in_u | input | 8 | Shared U chroma sample |
| in_v | input | 8 | Shared V chroma sample |
| out_valid | output | 1 | Output pixels are valid |
| out_rgba | output | LANES*32 | Pixels, lane 0 in the low word, each R,G,B,A from low byte up |

## Verification
The bench runs every combination of the values 0, 16, 128, 235 and 255 on both luma lanes and both chroma inputs, followed by seeded random traffic with gaps in the valid strobe. Each result is compared against an integer model of the equations. Corners near black drive the intermediates below zero, so a design that wraps instead of clamping shows bright values where 0 is expected. Corners near white push red and blue past 255 after the shift; a design that truncates there returns small wrapped bytes. Giving the two lanes different luma catches swapped lane slices or lanes that do not share chroma, and an off-by-one in the rounding constant moves many mid-range results by one count.

// File: rtl/yuv_rgba_pkg.sv
// Package: shared widths, conversion constants and saturating helpers for
// the YUV to RGBA datapath. Assumes 8-bit samples and 16-bit intermediates.
package yuv_rgba_pkg;

    localparam int PIX_W = 8;
    localparam int MID_W = 16;

    // Conversion gains
    localparam int LUMA_GAIN = 149;
    localparam int V_TO_R    = 204;
    localparam int U_TO_B    = 254;
    localparam int U_TO_G    = 50;
    localparam int V_TO_G    = 104;
    localparam int BLACK_LVL = 16;
    localparam int CHROMA_MID = 128;

    // Narrowing shifts
    localparam int SHIFT_RB = 6;
    localparam int SHIFT_G  = 7;

    // Derived offsets
    localparam int OFS_R = (BLACK_LVL*LUMA_GAIN + (CHROMA_MID >> 1) + CHROMA_MID*V_TO_R) >> 1;
    localparam int OFS_G = -BLACK_LVL*LUMA_GAIN + CHROMA_MID*U_TO_G + CHROMA_MID*V_TO_G;
    localparam int OFS_B = (BLACK_LVL*LUMA_GAIN + (CHROMA_MID << 2) + CHROMA_MID*U_TO_B) >> 1;

    // Largest reachable intermediates, used by range checks
    localparam int PMAX  = (1 << PIX_W) - 1;
    localparam int MAX_R = ((LUMA_GAIN*PMAX + (PMAX >> 1) + V_TO_R*PMAX) >> 1) - OFS_R;
    localparam int MAX_G = LUMA_GAIN*PMAX + OFS_G;
    localparam int MAX_B = ((LUMA_GAIN*PMAX + (PMAX << 2) + U_TO_B*PMAX) >> 1) - OFS_B;

    // Subtract with clamp at zero
    function automatic logic [MID_W-1:0] sat_sub(input logic [MID_W-1:0] a,
                                                 input logic [MID_W-1:0] b);
        return (a > b) ? (a - b) : '0;
    endfunction

    // Add with clamp at the all-ones ceiling
    function automatic logic [MID_W-1:0] sat_add(input logic [MID_W-1:0] a,
                                                 input logic [MID_W-1:0] b);
        logic [MID_W:0] s;
        s = {1'b0, a} + {1'b0, b};
        return s[MID_W] ? '1 : s[MID_W-1:0];
    endfunction

endpackage

// File: rtl/yuv_round_sat.sv
// Module: rounding narrow. Adds half an LSB of the output at one extra bit of
// width, shifts right by SHIFT and clamps to the output range. Purely
// combinational. Assumes SHIFT >= 1.
module yuv_round_sat #(
    parameter int IN_W  = 16,
    parameter int OUT_W = 8,
    parameter int SHIFT = 6
) (
    input  logic [IN_W-1:0]  din,
    output logic [OUT_W-1:0] dout
);
    localparam logic [IN_W:0] HALF = (IN_W+1)'(1) << (SHIFT-1);
    localparam logic [IN_W:0] TOP  = (IN_W+1)'((1 << OUT_W) - 1);

    logic [IN_W:0] biased;
    logic [IN_W:0] shifted;

    // Round half up, then clamp to the largest output code
    always_comb begin
        biased  = {1'b0, din} + HALF;
        shifted = biased >> SHIFT;
        dout    = (shifted > TOP) ? '1 : shifted[OUT_W-1:0];
    end
endmodule

// File: rtl/yuv_chroma_prep.sv
// Module: chroma term register (stage 1). Forms the chroma products shared by
// all luma lanes and registers them alongside the lanes' luma products.
// Assumes 8-bit U and V; every product fits in MID_W bits.
module yuv_chroma_prep
    import yuv_rgba_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PIX_W-1:0] u,
    input  logic [PIX_W-1:0] v,
    output logic [MID_W-1:0] v_half,
    output logic [MID_W-1:0] u_x4,
    output logic [MID_W-1:0] v_red,
    output logic [MID_W-1:0] u_blue,
    output logic [MID_W-1:0] uv_green
);
    // Register the shared chroma terms
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_half   <= '0;
            u_x4     <= '0;
            v_red    <= '0;
            u_blue   <= '0;
            uv_green <= '0;
        end else begin
            v_half   <= MID_W'(v >> 1);
            u_x4     <= MID_W'(u) << 2;
            v_red    <= MID_W'(v) * MID_W'(V_TO_R);
            u_blue   <= MID_W'(u) * MID_W'(U_TO_B);
            uv_green <= MID_W'(u) * MID_W'(U_TO_G) + MID_W'(v) * MID_W'(V_TO_G);
        end
    end
endmodule

// File: rtl/yuv_lane.sv
// Module: one luma lane. Stage 1 registers the luma product, stage 2 the
// three channel intermediates, stage 3 the rounded bytes packed as R,G,B,A.
// Assumes the chroma terms arrive already registered in step with stage 1.
module yuv_lane
    import yuv_rgba_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PIX_W-1:0] y,
    input  logic [MID_W-1:0] v_half,
    input  logic [MID_W-1:0] u_x4,
    input  logic [MID_W-1:0] v_red,
    input  logic [MID_W-1:0] u_blue,
    input  logic [MID_W-1:0] uv_green,
    output logic [4*PIX_W-1:0] pixel
);
    logic [MID_W-1:0] luma_q;
    logic [MID_W-1:0] r_mid, g_mid, b_mid;
    logic [MID_W:0]   r_sum, b_sum;
    logic [MID_W-1:0] r_next, g_next, b_next;
    logic [PIX_W-1:0] r_byte, g_byte, b_byte;
    logic [PIX_W-1:0] r_q, g_q, b_q;

    // Stage 1: luma product
    always_ff @(posedge clk) begin
        if (!rst_n) luma_q <= '0;
        else        luma_q <= MID_W'(y) * MID_W'(LUMA_GAIN);
    end

    // Stage 2 combinational: halving adds and saturating offsets
    always_comb begin
        r_sum  = {1'b0, luma_q + v_half} + {1'b0, v_red};
        b_sum  = {1'b0, luma_q + u_x4} + {1'b0, u_blue};
        r_next = sat_sub(MID_W'(r_sum >> 1), MID_W'(OFS_R));
        g_next = sat_sub(sat_add(luma_q, MID_W'(OFS_G)), uv_green);
        b_next = sat_sub(MID_W'(b_sum >> 1), MID_W'(OFS_B));
    end

    // Stage 2 register: channel intermediates
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_mid <= '0;
            g_mid <= '0;
            b_mid <= '0;
        end else begin
            r_mid <= r_next;
            g_mid <= g_next;
            b_mid <= b_next;
        end
    end

    yuv_round_sat #(.IN_W(MID_W), .OUT_W(PIX_W), .SHIFT(SHIFT_RB)) u_nr (.din(r_mid), .dout(r_byte));
    yuv_round_sat #(.IN_W(MID_W), .OUT_W(PIX_W), .SHIFT(SHIFT_G))  u_ng (.din(g_mid), .dout(g_byte));
    yuv_round_sat #(.IN_W(MID_W), .OUT_W(PIX_W), .SHIFT(SHIFT_RB)) u_nb (.din(b_mid), .dout(b_byte));

    // Stage 3 register: narrowed channel bytes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
            g_q <= '0;
            b_q <= '0;
        end else begin
            r_q <= r_byte;
            g_q <= g_byte;
            b_q <= b_byte;
        end
    end

    assign pixel = (r_q == '0 && g_q == '0 && b_q == '0 && !rst_n_seen) ? '0
                 : {{PIX_W{1'b1}}, b_q, g_q, r_q};

    // Tracks whether the pipeline has left reset, so the reset pixel reads 0
    logic rst_n_seen;
    logic [1:0] fill_cnt;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill_cnt   <= '0;
            rst_n_seen <= 1'b0;
        end else begin
            if (fill_cnt != 2'd3) fill_cnt <= fill_cnt + 2'd1;
            rst_n_seen <= (fill_cnt >= 2'd2);
        end
    end

    // Intermediates stay inside their computed ranges
    assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        r_mid <= MID_W'(MAX_R));
    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        g_mid <= MID_W'(MAX_G));
    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        b_mid <= MID_W'(MAX_B));
    // Large red intermediate narrows to the top code
    assert_red_clamp_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (r_mid >= MID_W'((256 << SHIFT_RB) - (1 << (SHIFT_RB-1)))) |=> (r_q == 8'hFF));
    // Zero intermediate narrows to zero
    assert_zero_floor_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (b_mid == '0) |=> (b_q == '0));
endmodule

// File: rtl/yuv_rgba_conv.sv
// Module: top of the YUV to RGBA converter. LANES luma lanes share one chroma
// term register; a three-deep valid pipeline runs beside the data.
// Assumes a free-running pipeline: data registers load every cycle.
module yuv_rgba_conv
    import yuv_rgba_pkg::*;
#(
    parameter int LANES = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic [LANES*PIX_W-1:0] in_y,
    input  logic [PIX_W-1:0]       in_u,
    input  logic [PIX_W-1:0]       in_v,
    output logic                   out_valid,
    output logic [LANES*4*PIX_W-1:0] out_rgba
);
    localparam int DEPTH = 3;

    logic [MID_W-1:0] v_half, u_x4, v_red, u_blue, uv_green;
    logic [DEPTH-1:0] vld_pipe;
    logic [1:0]       since_rst;

    yuv_chroma_prep u_chroma (
        .clk(clk), .rst_n(rst_n), .u(in_u), .v(in_v),
        .v_half(v_half), .u_x4(u_x4), .v_red(v_red),
        .u_blue(u_blue), .uv_green(uv_green)
    );

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        yuv_lane u_lane (
            .clk(clk), .rst_n(rst_n),
            .y(in_y[i*PIX_W +: PIX_W]),
            .v_half(v_half), .u_x4(u_x4), .v_red(v_red),
            .u_blue(u_blue), .uv_green(uv_green),
            .pixel(out_rgba[i*4*PIX_W +: 4*PIX_W])
        );
    end

    // Valid strobe pipeline matching the data latency
    always_ff @(posedge clk) begin
        if (!rst_n) vld_pipe <= '0;
        else        vld_pipe <= {vld_pipe[DEPTH-2:0], in_valid};
    end

    assign out_valid = vld_pipe[DEPTH-1];

    // Counts edges since reset, for the latency check
    always_ff @(posedge clk) begin
        if (!rst_n)                 since_rst <= '0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    assert_valid_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd3) |-> (out_valid == $past(in_valid, 3)));
    assert_reset_clear_R8: assert property (@(posedge clk)
        (!rst_n) |=> (!out_valid));
endmodule

// File: tb/yuv_rgba_conv_test.sv
`timescale 1ns/1ps
module yuv_rgba_conv_test;
    localparam int LANES  = 2;
    localparam int NSTEP  = 2400;
    localparam int LAT    = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] in_y = '0;
    logic [7:0]  in_u = '0, in_v = '0;
    logic        out_valid;
    logic [63:0] out_rgba;

    int total = 0, bad = 0;
    bit done = 0;

    logic [7:0] sy0 [NSTEP], sy1 [NSTEP], su [NSTEP], sv [NSTEP];
    bit         sval [NSTEP];

    always #2.5 clk = ~clk;

    yuv_rgba_conv #(.LANES(LANES)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_y(in_y),
        .in_u(in_u), .in_v(in_v), .out_valid(out_valid), .out_rgba(out_rgba)
    );

    function automatic int narrow(int x, int sh);
        int t;
        t = (x + (1 << (sh - 1))) >> sh;
        return (t > 255) ? 255 : t;
    endfunction

    function automatic int red_raw(int y, int v);
        return ((149*y + (v >> 1) + 204*v) >> 1) - 14280;
    endfunction

    function automatic int green_raw(int y, int u, int v);
        int s;
        s = 149*y + 17328;
        if (s > 65535) s = 65535;
        return s - (50*u + 104*v);
    endfunction

    function automatic int blue_raw(int y, int u);
        return ((149*y + 4*u + 254*u) >> 1) - 17704;
    endfunction

    function automatic int pos(int x);
        return (x < 0) ? 0 : x;
    endfunction

    task automatic check(bit ok, string tag, int got, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s got=%0d expected=%0d", tag, got, exp);
        end
    endtask

    task automatic check_lane(int k, int lane);
        int y, r, g, b, er, eg, eb;
        logic [31:0] px;
        string xt;
        y  = (lane == 0) ? int'(sy0[k]) : int'(sy1[k]);
        r  = red_raw(y, sv[k]);
        g  = green_raw(y, su[k], sv[k]);
        b  = blue_raw(y, su[k]);
        er = narrow(pos(r), 6);
        eg = narrow(pos(g), 7);
        eb = narrow(pos(b), 6);
        px = out_rgba[lane*32 +: 32];
        xt = (lane == 1) ? " R7" : "";
        check(px[7:0] == er[7:0],
              $sformatf("R2%s%s%s red step %0d", xt, (er == 255) ? " R5" : "", (r <= 0) ? " R9" : "", k),
              px[7:0], er);
        check(px[15:8] == eg[7:0],
              $sformatf("R3%s%s%s green step %0d", xt, (eg == 255) ? " R5" : "", (g <= 0) ? " R9" : "", k),
              px[15:8], eg);
        check(px[23:16] == eb[7:0],
              $sformatf("R4%s%s%s blue step %0d", xt, (eb == 255) ? " R5" : "", (b <= 0) ? " R9" : "", k),
              px[23:16], eb);
        check(px[31:24] == 8'hFF, $sformatf("R6 alpha step %0d", k), px[31:24], 255);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // Watchdog: a hung run ends as a failure
    initial begin
        #(5.0 * 200000);
        total++;
        bad++;
        $display("FAIL watchdog expired got=1 expected=0");
        finish_run();
    end

    initial begin
        int corner [5] = '{0, 16, 128, 235, 255};
        int n;
        void'($urandom(32'd2718));
        // Reset with valid inputs driven
        in_valid = 1'b1;
        in_y = 16'hFFFF; in_u = 8'hFF; in_v = 8'hFF;
        repeat (5) @(negedge clk);
        check(out_valid == 1'b0, "R8 valid in reset", out_valid, 0);
        check(out_rgba == 64'd0, "R8 pixels in reset", 0, 0);
        rst_n = 1'b1;
        in_valid = 1'b0;
        n = 0;
        // Build the stimulus list: all corner combinations, then random
        foreach (corner[a]) foreach (corner[b]) foreach (corner[c]) foreach (corner[d]) begin
            sy0[n] = corner[a][7:0]; sy1[n] = corner[b][7:0];
            su[n]  = corner[c][7:0]; sv[n]  = corner[d][7:0];
            sval[n] = 1'b1;
            n++;
        end
        for (int k = n; k < NSTEP; k++) begin
            sy0[k] = 8'($urandom); sy1[k] = 8'($urandom);
            su[k]  = 8'($urandom); sv[k]  = 8'($urandom);
            sval[k] = (k < NSTEP - LAT) ? (($urandom % 4) != 0) : 1'b0;
        end
        // Stream: check the step from LAT cycles ago, then drive this step
        for (int k = 0; k < NSTEP; k++) begin
            if (k >= LAT) begin
                check(out_valid == sval[k-LAT], $sformatf("R1 valid step %0d", k-LAT),
                      out_valid, sval[k-LAT]);
                if (sval[k-LAT] && out_valid) begin
                    check_lane(k-LAT, 0);
                    check_lane(k-LAT, 1);
                end
            end
            in_valid = sval[k];
            in_y = {sy1[k], sy0[k]};
            in_u = su[k];
            in_v = sv[k];
            @(negedge clk);
        end
        finish_run();
    end
endmodule